// File: doc/BRIEF.md
# Diagnostic Shadow Scan Register

This block is a parallel pipeline register with a second register beside it, the shadow register, which sits in a serial diagnostic loop. In normal operation the pipeline register takes the parallel input on each pipeline clock edge and drives the data path through a tri-state output stage. For diagnostics, a controller shifts a known pattern into the shadow register on the diagnostic clock. It then moves that pattern into the pipeline register to force a value into the data path. To observe the data path, the controller captures the pipeline value into the shadow register and shifts it out bit by bit for comparison.

The two registers run on independent clocks. A single mode select sets what both registers do. When the two clocks rise together in diagnostic mode, the registers swap contents, and each one takes the other's value from before the edge.

The parallel path and the serial path have no valid/ready handshake and no back-pressure. Each register acts on every rising edge of its own clock, so the caller controls data flow by gating the clocks. An active-low asynchronous reset clears both registers.

Top module: `scan_diag_reg`

## Requirements
- R1: While reset is asserted, and after it is released, both registers hold zero: the enabled parallel output reads 0x00 and the serial output reads 0.
- R2: With mode select low, each pipeline clock rising edge loads the parallel input into the pipeline register.
- R3: With mode select low, each diagnostic clock rising edge shifts the shadow register one place toward the LSB, and the serial input enters bit 7. After eight shifts, the first bit shifted in sits in bit 0.
- R4: The serial output always shows bit 0 of the shadow register. A captured byte therefore leaves the register LSB first, one bit per diagnostic clock edge.
- R5: With mode select high, each pipeline clock rising edge loads the shadow register contents into the pipeline register.
- R6: With mode select high and serial input low, each diagnostic clock rising edge loads the pipeline register value into the shadow register.
- R7: With mode select high and serial input high, diagnostic clock edges leave the shadow register unchanged.
- R8: When the active-low output enable is high, every parallel output bit is high impedance. Both registers keep loading and holding normally, and the pipeline value appears again once the outputs are enabled.
- R9: When both clocks rise together with mode select high and serial input low, the registers exchange their values. Each register receives the other's value from before the edge.
- R10: A pattern that is shifted in, transferred to the pipeline, captured back into the shadow register after the shadow has been cleared, and shifted out comes back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pipe_clk | input | 1 | Pipeline register clock |
| diag_clk | input | 1 | Shadow register clock |
| rst_n | input | 1 | Asynchronous active-low reset for both registers |
| sel_diag | input | 1 | Mode select: 0 = run/shift, 1 = transfer |
| par_in | input | 8 | Parallel data input |
| par_out | output | 8 | Tri-stated parallel output from the pipeline register |
| out_en_n | input | 1 | Active-low output enable |
| ser_in | input | 1 | Serial input to shadow bit 7; also picks capture or hold in mode 1 |
| ser_out | output | 1 | Serial output, shadow bit 0 |

## Verification
The parallel path is tested with 0xA5, 0x3C, 0xFF and 0x00. These values show whether every bit loads independently and can reach both levels. The serial path uses asymmetric patterns such as 0xB5 and 0x0F, so a reversed shift direction or a wrong entry bit shows up as a different byte. Coincident clock edges are tested with two unrelated values, 0x5A and 0xC3, so a swap that uses an updated value instead of the old one is caught. Disabled outputs are read through pull-ups and must read 0xFF while the pipeline holds 0x5A.

// File: rtl/scan_pkg.sv
`timescale 1ns/1ps
package scan_pkg;
  localparam int unsigned DEF_W = 8;

  typedef enum logic {
    SEL_RUN  = 1'b0,
    SEL_XFER = 1'b1
  } sel_e;

  typedef enum logic [1:0] {
    SH_SHIFT   = 2'd0,
    SH_CAPTURE = 2'd1,
    SH_HOLD    = 2'd2
  } shadow_op_e;
endpackage

// File: rtl/scan_pipe_stage.sv
`timescale 1ns/1ps
module scan_pipe_stage #(
  parameter int unsigned W = scan_pkg::DEF_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sel,
  input  logic [W-1:0] par_d,
  input  logic [W-1:0] shadow_d,
  output logic [W-1:0] q
);
  import scan_pkg::*;

  logic [W-1:0] nxt;

  // input multiplexer: parallel pins or shadow register
  always_comb begin
    if (sel_e'(sel) == SEL_XFER) nxt = shadow_d;
    else                         nxt = par_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= nxt;
  end
endmodule

// File: rtl/scan_shadow_stage.sv
`timescale 1ns/1ps
module scan_shadow_stage #(
  parameter int unsigned W = scan_pkg::DEF_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sel,
  input  logic         ser_in,
  input  logic [W-1:0] pipe_d,
  output logic [W-1:0] q,
  output logic         ser_out
);
  import scan_pkg::*;

  shadow_op_e   op;
  logic [W-1:0] shifted;
  logic [W-1:0] nxt;

  always_comb begin
    if (sel_e'(sel) == SEL_RUN) op = SH_SHIFT;
    else if (!ser_in)           op = SH_CAPTURE;
    else                        op = SH_HOLD;
  end

  // right shift: new bit enters the top, bit 0 leaves
  assign shifted[W-1] = ser_in;
  for (genvar i = 0; i < W - 1; i++) begin : g_shift
    assign shifted[i] = q[i+1];
  end

  always_comb begin
    unique case (op)
      SH_SHIFT:   nxt = shifted;
      SH_CAPTURE: nxt = pipe_d;
      default:    nxt = q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= nxt;
  end

  assign ser_out = q[0];
endmodule

// File: rtl/scan_out_buf.sv
`timescale 1ns/1ps
module scan_out_buf #(
  parameter int unsigned W = scan_pkg::DEF_W
) (
  input  logic         en_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] pad
);
  for (genvar i = 0; i < W; i++) begin : g_drv
    assign pad[i] = en_n ? 1'bz : d[i];
  end
endmodule

// File: rtl/scan_diag_reg.sv
`timescale 1ns/1ps
module scan_diag_reg #(
  parameter int unsigned W = scan_pkg::DEF_W
) (
  input  logic         pipe_clk,
  input  logic         diag_clk,
  input  logic         rst_n,
  input  logic         sel_diag,
  input  logic [W-1:0] par_in,
  output logic [W-1:0] par_out,
  input  logic         out_en_n,
  input  logic         ser_in,
  output logic         ser_out
);
  logic [W-1:0] pipe_q;
  logic [W-1:0] shadow_q;

  scan_pipe_stage #(.W(W)) u_pipe (
    .clk      (pipe_clk),
    .rst_n    (rst_n),
    .sel      (sel_diag),
    .par_d    (par_in),
    .shadow_d (shadow_q),
    .q        (pipe_q)
  );

  scan_shadow_stage #(.W(W)) u_shadow (
    .clk     (diag_clk),
    .rst_n   (rst_n),
    .sel     (sel_diag),
    .ser_in  (ser_in),
    .pipe_d  (pipe_q),
    .q       (shadow_q),
    .ser_out (ser_out)
  );

  scan_out_buf #(.W(W)) u_obuf (
    .en_n (out_en_n),
    .d    (pipe_q),
    .pad  (par_out)
  );
endmodule

// File: rtl/scan_diag_reg_chk.sv
`timescale 1ns/1ps
module scan_diag_reg_chk #(
  parameter int unsigned W = scan_pkg::DEF_W
) (
  input logic         pipe_clk,
  input logic         diag_clk,
  input logic         rst_n,
  input logic         sel_diag,
  input logic [W-1:0] par_in,
  input logic [W-1:0] par_out,
  input logic         out_en_n,
  input logic         ser_in,
  input logic         ser_out,
  input logic [W-1:0] pipe_q,
  input logic [W-1:0] shadow_q
);
  assert_par_load_R2: assert property (@(posedge pipe_clk) disable iff (!rst_n)
    !sel_diag |=> pipe_q == $past(par_in));

  assert_xfer_load_R5: assert property (@(posedge pipe_clk) disable iff (!rst_n)
    sel_diag |=> pipe_q == $past(shadow_q));

  assert_shift_right_R3: assert property (@(posedge diag_clk) disable iff (!rst_n)
    !sel_diag |=> shadow_q == {$past(ser_in), $past(shadow_q[W-1:1])});

  assert_ser_out_R4: assert property (@(posedge diag_clk) disable iff (!rst_n)
    !sel_diag |=> ser_out == $past(shadow_q[1]));

  assert_capture_R6: assert property (@(posedge diag_clk) disable iff (!rst_n)
    (sel_diag && !ser_in) |=> shadow_q == $past(pipe_q));

  assert_hold_R7: assert property (@(posedge diag_clk) disable iff (!rst_n)
    (sel_diag && ser_in) |=> $stable(shadow_q));

  assert_out_drive_R8: assert property (@(negedge pipe_clk) disable iff (!rst_n)
    !out_en_n |-> par_out == pipe_q);
endmodule

bind scan_diag_reg scan_diag_reg_chk #(.W(W)) chk_i (
  .pipe_clk (pipe_clk),
  .diag_clk (diag_clk),
  .rst_n    (rst_n),
  .sel_diag (sel_diag),
  .par_in   (par_in),
  .par_out  (par_out),
  .out_en_n (out_en_n),
  .ser_in   (ser_in),
  .ser_out  (ser_out),
  .pipe_q   (pipe_q),
  .shadow_q (shadow_q)
);

// File: tb/scan_diag_reg_tb_top.sv
`timescale 1ns/1ps
module scan_diag_reg_tb_top;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         pclk = 1'b0;
  logic         dclk = 1'b0;
  logic         rst_n = 1'b0;
  logic         sel = 1'b0;
  logic [W-1:0] din = '0;
  logic         oe_n = 1'b0;
  logic         sdi = 1'b0;
  wire          sdo;
  wire  [W-1:0] bus;

  int total = 0;
  int passed = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  for (genvar g = 0; g < W; g++) begin : g_pu
    pullup (bus[g]);
  end

  scan_diag_reg #(.W(W)) dut_i (
    .pipe_clk (pclk),
    .diag_clk (dclk),
    .rst_n    (rst_n),
    .sel_diag (sel),
    .par_in   (din),
    .par_out  (bus),
    .out_en_n (oe_n),
    .ser_in   (sdi),
    .ser_out  (sdo)
  );

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act === exp) passed++;
    else $display("FAIL %s actual=%h expected=%h", tag, act, exp);
  endtask

  // one clock period: edges in the middle, inputs stable around them
  task automatic pulse(input bit p, input bit d);
    #2;
    if (p) pclk = 1'b1;
    if (d) dclk = 1'b1;
    #4;
    pclk = 1'b0;
    dclk = 1'b0;
    #2;
  endtask

  task automatic shift_in(input logic [W-1:0] pat);
    sel = 1'b0;
    for (int i = 0; i < W; i++) begin
      sdi = pat[i];
      pulse(1'b0, 1'b1);
    end
    sdi = 1'b0;
  endtask

  task automatic shift_out(output logic [W-1:0] v);
    sel = 1'b0;
    sdi = 1'b0;
    for (int i = 0; i < W; i++) begin
      v[i] = sdo;
      pulse(1'b0, 1'b1);
    end
  endtask

  task automatic t_reset;
    oe_n = 1'b0;
    #1;
    check("R1 out during reset", bus, 8'h00);
    #10 rst_n = 1'b1;
    #5;
    check("R1 out after reset", bus, 8'h00);
    check("R1 sdo after reset", {7'b0, sdo}, 8'h00);
  endtask

  task automatic t_parallel;
    logic [W-1:0] pats [4] = '{8'hA5, 8'h3C, 8'hFF, 8'h00};
    sel = 1'b0;
    for (int i = 0; i < 4; i++) begin
      din = pats[i];
      pulse(1'b1, 1'b0);
      check("R2 parallel load", bus, pats[i]);
    end
  endtask

  task automatic t_shift_xfer;
    logic [W-1:0] pat = 8'hB5;
    logic [W-1:0] got;
    sel = 1'b0;
    for (int i = 0; i < W; i++) begin
      sdi = pat[i];
      pulse(1'b0, 1'b1);
      if (i == W - 2) check("R3 sdo before last shift", {7'b0, sdo}, 8'h00);
    end
    check("R3 first bit reaches LSB", {7'b0, sdo}, {7'b0, pat[0]});
    sel = 1'b1;
    pulse(1'b1, 1'b0);
    check("R5 shadow to pipe", bus, pat);
    shift_out(got);
    check("R4 serial readout LSB first", got, pat);
  endtask

  task automatic t_capture;
    logic [W-1:0] got;
    oe_n = 1'b1;
    sel = 1'b0;
    din = 8'h6D;
    pulse(1'b1, 1'b0);
    sel = 1'b1;
    sdi = 1'b0;
    pulse(1'b0, 1'b1);
    shift_out(got);
    check("R6 capture pipe into shadow", got, 8'h6D);
    oe_n = 1'b0;
    #1;
    check("R8 pipe kept while disabled", bus, 8'h6D);
  endtask

  task automatic t_hold;
    shift_in(8'h0F);
    din = 8'hF0;
    pulse(1'b1, 1'b0);
    sel = 1'b1;
    sdi = 1'b1;
    pulse(1'b0, 1'b1);
    pulse(1'b0, 1'b1);
    sdi = 1'b0;
    pulse(1'b1, 1'b0);
    check("R7 shadow held", bus, 8'h0F);
  endtask

  task automatic t_oe;
    oe_n = 1'b1;
    #1;
    check("R8 disabled reads high-z", bus, 8'hFF);
    sel = 1'b0;
    din = 8'h5A;
    pulse(1'b1, 1'b0);
    check("R8 still high-z after load", bus, 8'hFF);
    oe_n = 1'b0;
    #1;
    check("R8 load while disabled kept", bus, 8'h5A);
  endtask

  task automatic t_swap;
    logic [W-1:0] got;
    shift_in(8'hC3);
    sel = 1'b1;
    sdi = 1'b0;
    pulse(1'b1, 1'b1);
    check("R9 pipe gets old shadow", bus, 8'hC3);
    shift_out(got);
    check("R9 shadow gets old pipe", got, 8'h5A);
  endtask

  task automatic t_round_trip;
    logic [W-1:0] got;
    shift_in(8'h3C);
    sel = 1'b1;
    pulse(1'b1, 1'b0);
    shift_in(8'h00);
    sel = 1'b1;
    sdi = 1'b0;
    pulse(1'b0, 1'b1);
    shift_out(got);
    check("R10 round trip", got, 8'h3C);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000 && !done) begin
      done = 1'b1;
      total++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", passed, total);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_parallel();
    t_shift_xfer();
    t_capture();
    t_hold();
    t_oe();
    t_swap();
    t_round_trip();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", passed, total);
      $finish;
    end
  end
endmodule